// File: doc/BRIEF.md
# Variable-Count Bit Gearbox

This block turns a stream of recovered bits that arrives in uneven handfuls into a stream of words of constant width. In each clock cycle the producer offers a sample bus together with a count that says how many of its lowest bits are real; the count may be anything from zero to the full bus width, and it may change every cycle. The gearbox appends those bits to an internal shift buffer behind the bits it already holds. It emits one word with a valid strobe whenever enough bits have gathered.

Bit order is preserved throughout. The lowest bit of the sample bus is the earliest bit of that cycle, and the lowest bit of each output word is the earliest bit of that word. Bits that remain after a word is cut off stay in the buffer and move down to the low end, ready for the next word. The whole block runs on one clock. The output width is a parameter, and it must be large enough that one word per cycle keeps up with the peak input rate over any burst.

Top module: `bit_gearbox`

## Requirements
- R1: While reset is high at a clock edge, the buffer is emptied and, from the next cycle, `wordValid` is 0 and `wordOut` is all zeros.
- R2: Bits leave in the order they arrived. Sample bit 0 of a cycle follows the last bit of the previous cycle, and `wordOut[0]` is the oldest bit of each word.
- R3: Only sample bits below `sampleCount` are taken; bits at or above that position have no effect on any output word.
- R4: If the bits held plus the bits offered in a cycle reach `OUT_W`, then `wordValid` is 1 in the following cycle and `wordOut` carries the oldest `OUT_W` of those bits. At most one word is emitted per cycle.
- R5: A cycle with `sampleCount` equal to 0 adds no bits to the buffer.
- R6: A count equal to the full bus width (64 by default) is accepted in a single cycle without losing bits, provided the bits held plus the bits offered do not exceed the buffer depth of twice the larger of the bus width and `OUT_W`.
- R7: If the bits held plus the bits offered stay below `OUT_W`, then `wordValid` is 0 in the following cycle. Bits left after an emission are kept, and they open the next word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Single clock for all logic |
| rst | input | 1 | Synchronous reset, active high |
| samples | input | IN_W | Sample bus; valid bits packed from bit 0, bit 0 oldest |
| sampleCount | input | CNT_W | Number of valid bits on `samples` (0 to IN_W) |
| wordOut | output | OUT_W | Assembled word, bit 0 oldest |
| wordValid | output | 1 | High for exactly the cycles in which `wordOut` holds a new word |

## Verification
A wrong fill level shows up at the ports within one or two cycles. Either `wordValid` rises a cycle early or late against the count of bits supplied, or every later word is shifted by the size of the error. A misplaced insertion point or a bad mask corrupts the first word that contains the affected bits, and that word appears one cycle after those bits are offered. Because the bench keeps a bit-exact queue of everything supplied, one lost or extra bit changes every word that follows, so such a fault cannot stay hidden for long.

// File: rtl/gb_pkg.sv
package gb_pkg;
  // Width of level and position fields; holds buffer depths up to 255 bits.
  localparam int LVL_W = 8;

  typedef struct packed {
    logic             emit;      // cut one word this cycle
    logic [LVL_W-1:0] insertAt;  // bit position where new samples land
    logic [LVL_W-1:0] takeCount; // number of sample bits to accept
  } gbStrobe_t;
endpackage

// File: rtl/gb_ctrl.sv
module gb_ctrl #(
  parameter int OUT_W = 24,
  parameter int IN_W  = 64,
  parameter int CNT_W = 7,
  parameter int BUF_W = 128
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         sampleCount,
  output gb_pkg::gbStrobe_t        strobe,
  output logic [gb_pkg::LVL_W-1:0] fillLevel
);
  localparam int LW = gb_pkg::LVL_W;
  localparam logic [LW-1:0] IN_LIM  = LW'(IN_W);
  localparam logic [LW-1:0] OUT_LIM = LW'(OUT_W);

  logic [LW-1:0] levelQ, levelD, takeCnt, total;
  logic          emit;

  always_comb begin
    takeCnt = (LW'(sampleCount) > IN_LIM) ? IN_LIM : LW'(sampleCount);
    total   = levelQ + takeCnt;
    emit    = (total >= OUT_LIM);
    levelD  = emit ? (total - OUT_LIM) : total;
  end

  always_ff @(posedge clk) begin
    if (rst) levelQ <= '0;
    else     levelQ <= levelD;
  end

  assign strobe.emit      = emit;
  assign strobe.insertAt  = levelQ;
  assign strobe.takeCount = takeCnt;
  assign fillLevel        = levelQ;
endmodule

// File: rtl/gb_datapath.sv
module gb_datapath #(
  parameter int OUT_W = 24,
  parameter int IN_W  = 64,
  parameter int BUF_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IN_W-1:0]   samples,
  input  gb_pkg::gbStrobe_t strobe,
  output logic [OUT_W-1:0]  wordOut,
  output logic              wordValid
);
  localparam int LW = gb_pkg::LVL_W;

  logic [IN_W-1:0]  keepMask;
  logic [BUF_W-1:0] bufQ, incoming, merged;
  logic [OUT_W-1:0] wordQ;
  logic             validQ;

  // One compare per lane: lane i is kept when it lies below the count.
  for (genvar i = 0; i < IN_W; i++) begin : g_mask
    assign keepMask[i] = (LW'(i) < strobe.takeCount);
  end

  always_comb begin
    incoming = BUF_W'(samples & keepMask);
    merged   = bufQ | (incoming << strobe.insertAt);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bufQ   <= '0;
      wordQ  <= '0;
      validQ <= 1'b0;
    end else if (strobe.emit) begin
      wordQ  <= merged[OUT_W-1:0];
      bufQ   <= merged >> OUT_W;
      validQ <= 1'b1;
    end else begin
      bufQ   <= merged;
      validQ <= 1'b0;
    end
  end

  assign wordOut   = wordQ;
  assign wordValid = validQ;
endmodule

// File: rtl/bit_gearbox.sv
module bit_gearbox #(
  parameter int OUT_W = 24,
  parameter int IN_W  = 64,
  parameter int CNT_W = $clog2(IN_W + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IN_W-1:0]  samples,
  input  logic [CNT_W-1:0] sampleCount,
  output logic [OUT_W-1:0] wordOut,
  output logic             wordValid
);
  localparam int BUF_W = 2 * ((IN_W > OUT_W) ? IN_W : OUT_W);

  gb_pkg::gbStrobe_t             strobe;
  logic [gb_pkg::LVL_W-1:0]      fillLevel;

  gb_ctrl #(.OUT_W(OUT_W), .IN_W(IN_W), .CNT_W(CNT_W), .BUF_W(BUF_W)) u_ctrl (
    .clk(clk), .rst(rst), .sampleCount(sampleCount),
    .strobe(strobe), .fillLevel(fillLevel)
  );

  gb_datapath #(.OUT_W(OUT_W), .IN_W(IN_W), .BUF_W(BUF_W)) u_dp (
    .clk(clk), .rst(rst), .samples(samples), .strobe(strobe),
    .wordOut(wordOut), .wordValid(wordValid)
  );
endmodule

// File: rtl/gearbox_checker.sv
module gearbox_checker #(
  parameter int OUT_W = 24,
  parameter int IN_W  = 64,
  parameter int CNT_W = 7,
  parameter int BUF_W = 128
) (
  input logic                     clk,
  input logic                     rst,
  input logic [CNT_W-1:0]         sampleCount,
  input logic [gb_pkg::LVL_W-1:0] fillLevel,
  input logic                     wordValid
);
  localparam logic [8:0] OUT_L = 9'(OUT_W);
  localparam logic [8:0] IN_L  = 9'(IN_W);
  localparam logic [8:0] BUF_L = 9'(BUF_W);

  logic [8:0] offered, sumNow;
  always_comb begin
    offered = (9'(sampleCount) > IN_L) ? IN_L : 9'(sampleCount);
    sumNow  = 9'(fillLevel) + offered;
  end

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (!wordValid && fillLevel == '0));

  assert_level_track_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (9'(fillLevel) == $past(sumNow) - (wordValid ? OUT_L : 9'd0)));

  assert_emit_when_full_R4: assert property (@(posedge clk) disable iff (rst)
    (sumNow >= OUT_L) |=> wordValid);

  assert_idle_keeps_level_R5: assert property (@(posedge clk) disable iff (rst)
    (sampleCount == '0 && 9'(fillLevel) < OUT_L) |=> $stable(fillLevel));

  assert_no_overflow_R6: assert property (@(posedge clk) disable iff (rst)
    sumNow <= BUF_L);

  assert_hold_when_short_R7: assert property (@(posedge clk) disable iff (rst)
    (sumNow < OUT_L) |=> !wordValid);
endmodule

bind bit_gearbox gearbox_checker #(
  .OUT_W(OUT_W), .IN_W(IN_W), .CNT_W(CNT_W), .BUF_W(BUF_W)
) u_gearbox_checker (
  .clk(clk), .rst(rst), .sampleCount(sampleCount),
  .fillLevel(fillLevel), .wordValid(wordValid)
);

// File: tb/test_bit_gearbox.sv
module test_bit_gearbox;
  localparam int OUT_W = 24;
  localparam int IN_W  = 64;
  localparam int CNT_W = 7;
  localparam int BUF_W = 128;

  logic             clk = 1'b0;
  logic             rst;
  logic [IN_W-1:0]  samples;
  logic [CNT_W-1:0] sampleCount;
  logic [OUT_W-1:0] wordOut;
  logic             wordValid;

  int checks = 0;
  int errors = 0;
  bit model[$];
  logic             expValid;
  logic [OUT_W-1:0] expWord;
  string            curTag;

  always #4 clk = ~clk;

  bit_gearbox #(.OUT_W(OUT_W), .IN_W(IN_W), .CNT_W(CNT_W)) i_bit_gearbox (
    .clk(clk), .rst(rst), .samples(samples), .sampleCount(sampleCount),
    .wordOut(wordOut), .wordValid(wordValid)
  );

  function automatic logic [IN_W-1:0] rand64();
    return {$urandom(), $urandom()};
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Called at a falling edge: check the last cycle, then drive the next one.
  task automatic step(input logic [IN_W-1:0] s, input int c, input string tag);
    int cc;
    check({curTag, " valid"}, 64'(wordValid), 64'(expValid));
    if (expValid) check({curTag, " word"}, 64'(wordOut), 64'(expWord));
    cc = c;
    if (model.size() + cc > BUF_W) cc = BUF_W - model.size();
    samples     = s;
    sampleCount = CNT_W'(cc);
    for (int i = 0; i < cc; i++) model.push_back(s[i]);
    if (model.size() >= OUT_W) begin
      for (int i = 0; i < OUT_W; i++) expWord[i] = model.pop_front();
      expValid = 1'b1;
    end else begin
      expValid = 1'b0;
    end
    curTag = tag;
    @(negedge clk);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; samples = '1; sampleCount = 7'd40;
    expValid = 1'b0; expWord = '0; curTag = "R1";
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset valid", 64'(wordValid), 64'(0));
    check("R1 reset word", 64'(wordOut), 64'(0));
    rst = 1'b0;

    // R5: zero counts with garbage on the bus add nothing
    for (int k = 0; k < 3; k++) step('1, 0, "R5");
    // R2: single bits fill one word; the last one completes it
    for (int k = 0; k < OUT_W; k++) step(rand64(), 1, "R2");
    step('0, 0, "R2");
    // R4: an exact full word in one cycle from an empty buffer
    step(rand64(), OUT_W, "R4");
    step('0, 0, "R4");
    // R7: leftover bits open the next word
    step(rand64(), 30, "R7");
    step(rand64(), 18, "R7");
    step(rand64(), 5, "R7");
    // R6: full-width burst while a word is being cut
    step(rand64(), 20, "R6");
    step('1, 64, "R6");
    step(rand64(), 64, "R6");
    for (int k = 0; k < 6; k++) step('0, 0, "R6");
    // R3: random counts with random garbage above the count
    for (int k = 0; k < 600; k++) begin
      int c;
      c = ($urandom() % 8 == 0) ? 64 : int'($urandom() % (OUT_W + 4));
      step(rand64(), c, "R3");
      if (c == 64) begin
        step(rand64(), 0, "R3");
        step(rand64(), 0, "R3");
      end
    end
    for (int k = 0; k < 8; k++) step('1, 0, "R3");
    // R1: reset mid-stream empties the buffer
    step(rand64(), 10, "R1");
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    model.delete();
    expValid = 1'b0;
    check("R1 reset valid", 64'(wordValid), 64'(0));
    for (int k = 0; k < OUT_W; k++) step(rand64(), 1, "R1");
    step('0, 0, "R1");
    step('0, 0, "R1");

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule